// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between a processor and the interrupt sources that target it. It holds one pending interrupt at a time in a 32-bit word. The upper byte of that word is the processor's current priority and the lower 24 bits are the number of the pending source. Beside that word it keeps the priority of the pending entry and a priority register for inter-processor interrupts (IPI). Numerically lower priorities are more favoured, and 0xff means nothing at all.

Sources offer requests made of a number, a priority and an owner tag. The presenter either takes a request or turns it away on the bounce port. A taken request can push out a less favoured external entry, which is then handed back to its owner on the evict port. Software drives single-cycle operations:
- accept: claims the pending interrupt;
- poll: reads the state without changing it;
- set current priority;
- set IPI priority;
- end-of-interrupt: forwarded to the sources.

When the presenter runs empty in a way that could strand interrupts, it raises a one-cycle resend request so that the sources offer again. A single line, `irq_out`, tells the processor that something is pending.

The pending entry is tracked by a three-state machine:
- PS_EMPTY: nothing is pending.
- PS_EXT: an external source is pending. Its owner tag is held.
- PS_IPI: the IPI is pending, with fixed source number 2.

Transitions:
- PS_EMPTY→PS_EXT and PS_IPI→PS_EXT: admit.
- PS_EXT→PS_EXT: displace.
- PS_EMPTY/PS_EXT→PS_IPI: IPI check, or a resend that finds the IPI favoured.
- any→PS_EMPTY: accept, or a priority raise that masks the entry.

Top module: `irq_presenter`

## Requirements
- R1: After reset the combined word reads 0, the IPI priority reads 0xff, the pending priority is 0xff and `irq_out` is low. All pulse outputs are low.
- R2: A request whose priority is greater than or equal to the current priority is bounced. Bounced means `bounce_valid` is high one cycle later, carrying its number and owner. The state does not change.
- R3: A request is also bounced when an entry is pending whose pending priority is less than or equal to the request's priority.
- R4: Any other request is taken one cycle later. Its number and priority are latched and `irq_out` goes high. A pending external entry is evicted on `evict_valid`/`evict_src`/`evict_owner` in that same cycle.
- R5: Accept (op code 1) returns {current priority, source number} on `rd_data` with `rd_valid` one cycle later. The current priority becomes the old pending priority, the number and line clear, and the pending priority returns to 0xff.
- R6: Poll (op code 2) returns the combined word on `rd_data` and the IPI priority on `rd_ipi`, with no state change.
- R7: Set IPI priority (op code 4, value in `op_data[7:0]`) stores the value. If the value is below the current priority and the pending entry is not at least as favoured, source 2 is latched at that priority, the line is raised, and a pending external entry is evicted.
- R8: Set current priority (op code 3, value in `op_data[7:0]`) to a more favoured value clears a pending entry whose priority is not below the new value, and lowers the line. An external entry cleared this way is evicted.
- R9: Set current priority to an equal or less favoured value while nothing is pending pulses `resend_req`. If the IPI priority is below the new current priority, it first latches the IPI.
- R10: End-of-interrupt (op code 5) loads the current priority from `op_data[31:24]` and pulses `eoi_valid` with `op_data[23:0]`. If nothing is pending, it then performs the resend of R9 against the new priority.
- R11: A request presented in the same cycle as any operation is bounced. The operation alone acts on the state.
- R12: An IPI entry that is displaced or cleared is never evicted. `evict_valid` only ever carries external source numbers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Source request strobe |
| req_src | input | 24 | Requesting source number |
| req_prio | input | 8 | Requesting priority |
| req_owner | input | 4 | Tag of the source unit issuing the request |
| op_valid | input | 1 | Software operation strobe |
| op_code | input | 3 | 1 accept, 2 poll, 3 set priority, 4 set IPI priority, 5 end-of-interrupt |
| op_data | input | 32 | Operation operand |
| irq_out | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Combined word returned by accept or poll |
| rd_ipi | output | 8 | IPI priority returned by poll |
| bounce_valid | output | 1 | A request was turned away |
| bounce_src | output | 24 | Number of the bounced request |
| bounce_owner | output | 4 | Owner of the bounced request |
| evict_valid | output | 1 | A pending external entry was handed back |
| evict_src | output | 24 | Number of the evicted entry |
| evict_owner | output | 4 | Owner of the evicted entry |
| eoi_valid | output | 1 | End-of-interrupt notice to sources |
| eoi_src | output | 24 | Source number of the notice |
| resend_req | output | 1 | Ask all sources to offer again |

## Verification
Some properties are checked on every cycle:
- the line always agrees with a nonzero pending number;
- a pending entry always carries a real priority;
- evictions never name the IPI or number zero;
- bounce, read and end-of-interrupt pulses only follow their own stimulus.

Other behaviour depends on priority ordering and is shown only by the directed scenarios:
- which of two competing requests wins;
- that the IPI check leaves a more favoured entry alone;
- that resend latches the IPI only when it beats the new priority;
- that accept moves the pending priority into the current priority.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_ACCEPT   = 3'd1,
        OP_POLL     = 3'd2,
        OP_SET_CPPR = 3'd3,
        OP_SET_IPI  = 3'd4,
        OP_EOI      = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        PS_EMPTY = 2'd0,
        PS_EXT   = 2'd1,
        PS_IPI   = 2'd2
    } pend_e;

endpackage

// File: rtl/irqp_admit.sv
module irqp_admit #(
    parameter int PRIO_W = 8
) (
    input  logic              pend,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] req_prio,
    output logic              take
);
    // Must beat the processor priority and any pending entry strictly.
    always_comb begin
        take = (req_prio < cur_prio) && (!pend || (req_prio < pend_prio));
    end
endmodule

// File: rtl/irqp_ipi_check.sv
module irqp_ipi_check #(
    parameter int PRIO_W = 8
) (
    input  logic              pend,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] ipi_prio,
    output logic              fire
);
    // The IPI yields to a pending entry that is at least as favoured.
    always_comb begin
        fire = !(pend && (pend_prio <= ipi_prio));
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter #(
    parameter int          PRIO_W  = 8,
    parameter int          SRC_W   = 24,
    parameter int          OWNER_W = 4,
    parameter int unsigned IPI_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [SRC_W-1:0]          req_src,
    input  logic [PRIO_W-1:0]         req_prio,
    input  logic [OWNER_W-1:0]        req_owner,
    input  logic                      op_valid,
    input  logic [2:0]                op_code,
    input  logic [PRIO_W+SRC_W-1:0]   op_data,
    output logic                      irq_out,
    output logic                      rd_valid,
    output logic [PRIO_W+SRC_W-1:0]   rd_data,
    output logic [PRIO_W-1:0]         rd_ipi,
    output logic                      bounce_valid,
    output logic [SRC_W-1:0]          bounce_src,
    output logic [OWNER_W-1:0]        bounce_owner,
    output logic                      evict_valid,
    output logic [SRC_W-1:0]          evict_src,
    output logic [OWNER_W-1:0]        evict_owner,
    output logic                      eoi_valid,
    output logic [SRC_W-1:0]          eoi_src,
    output logic                      resend_req
);
    import irqp_pkg::*;

    localparam int                  DW       = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0]   PRIO_OFF = '1;
    localparam logic [SRC_W-1:0]    IPI_NUM  = SRC_W'(IPI_SRC);

    pend_e               state_q, state_d;
    logic [PRIO_W-1:0]   cppr_q, cppr_d;
    logic [SRC_W-1:0]    xisr_q, xisr_d;
    logic [PRIO_W-1:0]   pprio_q, pprio_d;
    logic [PRIO_W-1:0]   mfrr_q, mfrr_d;
    logic [OWNER_W-1:0]  owner_q, owner_d;

    logic                rd_v_d, bounce_d, evict_d, eoi_d, resend_d;
    logic [DW-1:0]       rd_data_d;
    logic [PRIO_W-1:0]   rd_ipi_d;

    logic                pend;
    logic                take, ipi_fire;
    logic                do_resend, latch_ipi;
    logic [PRIO_W-1:0]   resend_cur, ipi_lvl;
    logic [PRIO_W-1:0]   op_prio, op_cur;
    op_e                 op_dec;

    assign pend    = (state_q != PS_EMPTY);
    assign op_prio = op_data[PRIO_W-1:0];
    assign op_cur  = op_data[DW-1:SRC_W];
    assign op_dec  = op_e'(op_code);

    irqp_admit #(.PRIO_W(PRIO_W)) u_admit (
        .pend      (pend),
        .cur_prio  (cppr_q),
        .pend_prio (pprio_q),
        .req_prio  (req_prio),
        .take      (take)
    );

    irqp_ipi_check #(.PRIO_W(PRIO_W)) u_ipi (
        .pend      (pend),
        .pend_prio (pprio_q),
        .ipi_prio  (op_prio),
        .fire      (ipi_fire)
    );

    // Next-state process: operations take precedence over requests.
    always_comb begin
        state_d    = state_q;
        cppr_d     = cppr_q;
        xisr_d     = xisr_q;
        pprio_d    = pprio_q;
        mfrr_d     = mfrr_q;
        owner_d    = owner_q;
        rd_v_d     = 1'b0;
        rd_data_d  = rd_data;
        rd_ipi_d   = rd_ipi;
        bounce_d   = 1'b0;
        evict_d    = 1'b0;
        eoi_d      = 1'b0;
        resend_d   = 1'b0;
        do_resend  = 1'b0;
        latch_ipi  = 1'b0;
        resend_cur = cppr_q;
        ipi_lvl    = mfrr_q;

        if (op_valid) begin
            bounce_d = req_valid;
            unique case (op_dec)
                OP_ACCEPT: begin
                    rd_v_d    = 1'b1;
                    rd_data_d = {cppr_q, xisr_q};
                    cppr_d    = pprio_q;
                    xisr_d    = '0;
                    pprio_d   = PRIO_OFF;
                    state_d   = PS_EMPTY;
                end
                OP_POLL: begin
                    rd_v_d    = 1'b1;
                    rd_data_d = {cppr_q, xisr_q};
                    rd_ipi_d  = mfrr_q;
                end
                OP_SET_CPPR: begin
                    cppr_d = op_prio;
                    if (op_prio < cppr_q) begin
                        if (pend && (op_prio <= pprio_q)) begin
                            evict_d = (state_q == PS_EXT);
                            xisr_d  = '0;
                            pprio_d = PRIO_OFF;
                            state_d = PS_EMPTY;
                        end
                    end else if (!pend) begin
                        do_resend  = 1'b1;
                        resend_cur = op_prio;
                    end
                end
                OP_SET_IPI: begin
                    mfrr_d = op_prio;
                    if ((op_prio < cppr_q) && ipi_fire) begin
                        evict_d   = (state_q == PS_EXT);
                        latch_ipi = 1'b1;
                        ipi_lvl   = op_prio;
                    end
                end
                OP_EOI: begin
                    cppr_d = op_cur;
                    eoi_d  = 1'b1;
                    if (!pend) begin
                        do_resend  = 1'b1;
                        resend_cur = op_cur;
                    end
                end
                default: ;
            endcase
        end else if (req_valid) begin
            if (take) begin
                evict_d = (state_q == PS_EXT);
                xisr_d  = req_src;
                pprio_d = req_prio;
                owner_d = req_owner;
                state_d = PS_EXT;
            end else begin
                bounce_d = 1'b1;
            end
        end

        if (do_resend) begin
            resend_d = 1'b1;
            if (mfrr_q < resend_cur) begin
                latch_ipi = 1'b1;
                ipi_lvl   = mfrr_q;
            end
        end

        if (latch_ipi) begin
            xisr_d  = IPI_NUM;
            pprio_d = ipi_lvl;
            state_d = PS_IPI;
        end
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= PS_EMPTY;
            cppr_q       <= '0;
            xisr_q       <= '0;
            pprio_q      <= PRIO_OFF;
            mfrr_q       <= PRIO_OFF;
            owner_q      <= '0;
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            rd_ipi       <= '0;
            bounce_valid <= 1'b0;
            bounce_src   <= '0;
            bounce_owner <= '0;
            evict_valid  <= 1'b0;
            evict_src    <= '0;
            evict_owner  <= '0;
            eoi_valid    <= 1'b0;
            eoi_src      <= '0;
            resend_req   <= 1'b0;
        end else begin
            state_q      <= state_d;
            cppr_q       <= cppr_d;
            xisr_q       <= xisr_d;
            pprio_q      <= pprio_d;
            mfrr_q       <= mfrr_d;
            owner_q      <= owner_d;
            rd_valid     <= rd_v_d;
            rd_data      <= rd_data_d;
            rd_ipi       <= rd_ipi_d;
            bounce_valid <= bounce_d;
            bounce_src   <= req_src;
            bounce_owner <= req_owner;
            evict_valid  <= evict_d;
            evict_src    <= xisr_q;
            evict_owner  <= owner_q;
            eoi_valid    <= eoi_d;
            eoi_src      <= op_data[SRC_W-1:0];
            resend_req   <= resend_d;
        end
    end

    assign irq_out = (state_q != PS_EMPTY);

endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
    parameter int          PRIO_W  = 8,
    parameter int          SRC_W   = 24,
    parameter int unsigned IPI_SRC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic              irq_out,
    input logic              rd_valid,
    input logic              bounce_valid,
    input logic              evict_valid,
    input logic [SRC_W-1:0]  evict_src,
    input logic              eoi_valid,
    input logic [SRC_W-1:0]  xisr,
    input logic [PRIO_W-1:0] pprio
);
    AST_LINE_MATCHES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (xisr != '0)); // R4

    AST_PENDING_HAS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (pprio != '1)); // R5

    AST_EVICT_EXTERNAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> ((evict_src != SRC_W'(IPI_SRC)) && (evict_src != '0))); // R12

    AST_BOUNCE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bounce_valid |-> $past(req_valid)); // R2

    AST_READ_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(op_valid && ((op_code == 3'd1) || (op_code == 3'd2)))); // R6

    AST_EOI_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(op_valid && (op_code == 3'd5))); // R10
endmodule

bind irq_presenter irqp_checker #(
    .PRIO_W  (PRIO_W),
    .SRC_W   (SRC_W),
    .IPI_SRC (IPI_SRC)
) u_irqp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .irq_out      (irq_out),
    .rd_valid     (rd_valid),
    .bounce_valid (bounce_valid),
    .evict_valid  (evict_valid),
    .evict_src    (evict_src),
    .eoi_valid    (eoi_valid),
    .xisr         (xisr_q),
    .pprio        (pprio_q)
);

// File: tb/test_irq_presenter.sv
module test_irq_presenter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_src = '0;
    logic [7:0]  req_prio = '0;
    logic [3:0]  req_owner = '0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] op_data = '0;
    logic        irq_out, rd_valid, bounce_valid, evict_valid, eoi_valid, resend_req;
    logic [31:0] rd_data;
    logic [7:0]  rd_ipi;
    logic [23:0] bounce_src, evict_src, eoi_src;
    logic [3:0]  bounce_owner, evict_owner;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_presenter i_irq_presenter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio), .req_owner(req_owner),
        .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
        .irq_out(irq_out), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ipi(rd_ipi),
        .bounce_valid(bounce_valid), .bounce_src(bounce_src), .bounce_owner(bounce_owner),
        .evict_valid(evict_valid), .evict_src(evict_src), .evict_owner(evict_owner),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus; outputs are checked at the following negedge.
    task automatic step(input logic rv, input logic [23:0] s, input logic [7:0] p,
                        input logic [3:0] o, input logic ov, input logic [2:0] c,
                        input logic [31:0] d);
        req_valid = rv; req_src = s; req_prio = p; req_owner = o;
        op_valid = ov; op_code = c; op_data = d;
        @(negedge clk);
        req_valid = 1'b0; op_valid = 1'b0;
    endtask

    task automatic req(input logic [23:0] s, input logic [7:0] p, input logic [3:0] o);
        step(1'b1, s, p, o, 1'b0, 3'd0, 32'd0);
    endtask

    task automatic op(input logic [2:0] c, input logic [31:0] d);
        step(1'b0, 24'd0, 8'd0, 4'd0, 1'b1, c, d);
    endtask

    task automatic poll_expect(input string tag, input logic [31:0] word);
        op(3'd2, 32'd0);
        chk(tag, rd_data, word);
    endtask

    task automatic t_reset;
        chk("R1 irq", {31'd0, irq_out}, 32'd0);
        chk("R1 pulses", {26'd0, rd_valid, bounce_valid, evict_valid, eoi_valid, resend_req, 1'b0}, 32'd0);
        op(3'd2, 32'd0);
        chk("R1 word", rd_data, 32'h0000_0000);
        chk("R1 ipi", {24'd0, rd_ipi}, 32'h0000_00ff);
    endtask

    task automatic t_bounce_and_admit;
        req(24'h5, 8'd5, 4'd9);
        chk("R2 bounce", {31'd0, bounce_valid}, 32'd1);
        chk("R2 bounce src", {8'd0, bounce_src}, 32'h5);
        chk("R2 irq", {31'd0, irq_out}, 32'd0);
        op(3'd3, 32'hff);
        chk("R9 resend", {31'd0, resend_req}, 32'd1);
        chk("R9 no ipi", {31'd0, irq_out}, 32'd0);
        req(24'h10, 8'd8, 4'd1);
        chk("R4 irq", {31'd0, irq_out}, 32'd1);
        chk("R4 no evict", {31'd0, evict_valid}, 32'd0);
        req(24'h20, 8'd8, 4'd2);
        chk("R3 bounce", {31'd0, bounce_valid}, 32'd1);
        chk("R3 owner", {28'd0, bounce_owner}, 32'd2);
        poll_expect("R3 unchanged", 32'hff00_0010);
    endtask

    task automatic t_displace;
        req(24'h30, 8'd3, 4'd3);
        chk("R4 evict", {31'd0, evict_valid}, 32'd1);
        chk("R4 evict src", {8'd0, evict_src}, 32'h10);
        chk("R4 evict owner", {28'd0, evict_owner}, 32'd1);
        poll_expect("R4 latched", 32'hff00_0030);
    endtask

    task automatic t_accept;
        op(3'd1, 32'd0);
        chk("R5 rd_valid", {31'd0, rd_valid}, 32'd1);
        chk("R5 value", rd_data, 32'hff00_0030);
        chk("R5 irq low", {31'd0, irq_out}, 32'd0);
        poll_expect("R5 cppr", 32'h0300_0000);
        poll_expect("R6 stable", 32'h0300_0000);
        chk("R6 ipi", {24'd0, rd_ipi}, 32'hff);
    endtask

    task automatic t_eoi;
        op(3'd5, 32'hff00_0030);
        chk("R10 eoi", {31'd0, eoi_valid}, 32'd1);
        chk("R10 eoi src", {8'd0, eoi_src}, 32'h30);
        chk("R10 resend", {31'd0, resend_req}, 32'd1);
        poll_expect("R10 cppr", 32'hff00_0000);
    endtask

    task automatic t_ipi;
        req(24'h40, 8'd6, 4'd4);
        op(3'd4, 32'd7);
        chk("R7 no evict", {31'd0, evict_valid}, 32'd0);
        poll_expect("R7 kept", 32'hff00_0040);
        chk("R7 ipi reg", {24'd0, rd_ipi}, 32'd7);
        op(3'd4, 32'd2);
        chk("R7 evict", {31'd0, evict_valid}, 32'd1);
        chk("R7 evict owner", {28'd0, evict_owner}, 32'd4);
        poll_expect("R7 ipi latched", 32'hff00_0002);
        req(24'h50, 8'd1, 4'd5);
        chk("R12 no evict on displace", {31'd0, evict_valid}, 32'd0);
        op(3'd1, 32'd0);
        chk("R5 accept ext", rd_data, 32'hff00_0050);
        op(3'd3, 32'd4);
        chk("R9 resend", {31'd0, resend_req}, 32'd1);
        chk("R9 ipi irq", {31'd0, irq_out}, 32'd1);
        poll_expect("R9 ipi word", 32'h0400_0002);
        op(3'd3, 32'd1);
        chk("R8 irq low", {31'd0, irq_out}, 32'd0);
        chk("R12 no evict on clear", {31'd0, evict_valid}, 32'd0);
        poll_expect("R8 word", 32'h0100_0000);
    endtask

    task automatic t_cppr;
        op(3'd4, 32'hff);
        op(3'd3, 32'hff);
        chk("R9 plain resend", {31'd0, resend_req}, 32'd1);
        chk("R9 no ipi", {31'd0, irq_out}, 32'd0);
        req(24'h60, 8'd9, 4'd6);
        op(3'd3, 32'd9);
        chk("R8 evict", {31'd0, evict_valid}, 32'd1);
        chk("R8 evict src", {8'd0, evict_src}, 32'h60);
        chk("R8 irq", {31'd0, irq_out}, 32'd0);
        op(3'd3, 32'hff);
        req(24'h61, 8'd9, 4'd6);
        op(3'd3, 32'h14);
        chk("R8 kept irq", {31'd0, irq_out}, 32'd1);
        chk("R8 kept no evict", {31'd0, evict_valid}, 32'd0);
        poll_expect("R8 kept word", 32'h1400_0061);
        op(3'd5, 32'hff00_0061);
        chk("R10 no resend", {31'd0, resend_req}, 32'd0);
        poll_expect("R10 pending kept", 32'hff00_0061);
    endtask

    task automatic t_collide;
        step(1'b1, 24'h70, 8'd1, 4'd7, 1'b1, 3'd2, 32'd0);
        chk("R11 bounce", {31'd0, bounce_valid}, 32'd1);
        chk("R11 bounce src", {8'd0, bounce_src}, 32'h70);
        chk("R11 poll", rd_data, 32'hff00_0061);
        poll_expect("R11 unchanged", 32'hff00_0061);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bounce_and_admit();
        t_displace();
        t_accept();
        t_eoi();
        t_ipi();
        t_cppr();
        t_collide();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule